// File: doc/BRIEF.md
# NAND Flash Instruction Sequencer

This block runs a short microprogram against a NAND flash device. Software loads a program word of packed 4-bit opcodes and pulses `start`. The block then works through the opcodes from the most significant nibble downward. Each step either sends a command byte, sends address bytes, moves data between the flash and the host-side buffer streams, moves one or two bytes through a small data register, or waits for the device's ready line before acting. The program stops at the first end opcode, or after the last slot.

Command bytes come from a 32-bit command word. Column and page indices come from a page-address word, and the block index from its own input. A transfer length sets how many bytes a buffer step moves. The number of row-address bytes and the wait timeout are simple mode inputs. When the run ends, the block pulses `done` and raises either a completion flag or a timeout flag. Both flags hold until the next start.

Data written to the flash arrives on a valid/ready input stream, and a byte is taken only in a cycle where both are high. Data read from the flash leaves on a valid/ready output stream. Once `m_valid` rises, it and `m_data` hold until `m_ready` accepts the byte. The sequencer stalls while the consumer pushes back, and it does not finish while a read byte is still waiting.

Top module: `nand_op_sequencer`

## Requirements
- R1: Opcodes run in order from bits 31:28 (first) down to bits 3:0 (last). A program with no end opcode runs all eight slots and then finishes.
- R2: Opcode 0x0 or 0xF ends the run, and no later slot is executed. The end is signalled by a one-cycle `done` pulse with `cmd_cplt` set and `wait_to` clear.
- R3: Opcodes 0x4, 0x5, 0x6 and 0x7 each send one byte with `nf_cle` and `nf_we` high. The byte is taken from `cmd_word` bits 31:24, 23:16, 15:8 and 7:0 respectively.
- R4: Opcode 0x1 sends the column index `page_addr[10:0]` as two bytes with `nf_ale` high, low byte first.
- R5: Opcode 0x2 sends the row value, which is `blk_addr` followed by the page index `page_addr[17:12]` in the low six bits. Opcode 0x3 sends `user_addr`. Both send `addr_cyc`+1 bytes with `nf_ale` high, least significant byte first.
- R6: Opcode 0x8 writes `byte_cnt` bytes taken from the input stream to the flash. `s_ready` is high only while such bytes remain, and a count of zero consumes nothing.
- R7: Opcode 0xA reads `byte_cnt` bytes from the flash onto the output stream. `m_valid` and `m_data` hold until accepted, and `done` never rises while `m_valid` is high.
- R8: Opcode 0x9 writes `sgl_wdata` to the flash, and opcode 0xB reads into `sgl_rdata`. Each moves one byte, or two when `sgl_two` is set, low byte first.
- R9: Opcodes 0xC and 0xD wait until `nf_ready` is high and then send CMD0 or CMD1 respectively. Opcode 0xE waits the same way and then performs the 0xA read. No strobe is issued while waiting.
- R10: If `nf_ready` stays low for (`wait_tmo`+1)·2^TMO_SHIFT cycles of a wait, the run aborts. `wait_to` is set, `cmd_cplt` stays clear, and `done` pulses with no further strobes.
- R11: `start` is ignored while `busy` is high. An accepted start clears both flags.
- R12: After reset, `busy`, `done`, both flags, all strobes, `s_ready` and `m_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe |
| prog_word | input | 32 | Packed opcodes, first in bits 31:28 |
| cmd_word | input | 32 | Four command bytes |
| blk_addr | input | 24 | Block index |
| page_addr | input | 32 | Page index at 17:12, column at 10:0 |
| user_addr | input | 32 | Free address value |
| byte_cnt | input | 12 | Buffer transfer length |
| addr_cyc | input | 2 | Row/user address bytes minus one |
| wait_tmo | input | 4 | Wait timeout setting |
| sgl_two | input | 1 | Single-byte steps move two bytes |
| sgl_wdata | input | 16 | Data for the single write step |
| sgl_rdata | output | 16 | Result of the single read step |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle end pulse |
| cmd_cplt | output | 1 | Run ended normally |
| wait_to | output | 1 | Run aborted by wait timeout |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we | output | 1 | Write strobe, one byte per cycle |
| nf_re | output | 1 | Read strobe, byte sampled at cycle end |
| nf_dq_o | output | 8 | Byte to flash |
| nf_dq_i | input | 8 | Byte from flash |
| nf_ready | input | 1 | Device ready (high) |
| s_valid | input | 1 | Write stream valid |
| s_ready | output | 1 | Write stream ready |
| s_data | input | 8 | Write stream byte |
| m_valid | output | 1 | Read stream valid |
| m_ready | input | 1 | Read stream ready |
| m_data | output | 8 | Read stream byte |

## Verification
The bench builds the block with TMO_SHIFT=2 and the default eight opcode slots and 12-bit count. With this setting, a timeout setting of 1 expires after eight low cycles of the ready line, and a setting of 15 gives a 64-cycle window. A bench-side pulse of the ready line can therefore land either inside or outside the window. Gapped input valid and a stalling output ready exercise the back-pressure rules within a few bytes.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  typedef enum logic [3:0] {
    OP_END   = 4'h0, OP_COL  = 4'h1, OP_ROW  = 4'h2, OP_USR  = 4'h3,
    OP_CMD0  = 4'h4, OP_CMD1 = 4'h5, OP_CMD2 = 4'h6, OP_CMD3 = 4'h7,
    OP_WBUF  = 4'h8, OP_WSGL = 4'h9, OP_RBUF = 4'hA, OP_RSGL = 4'hB,
    OP_WCMD0 = 4'hC, OP_WCMD1 = 4'hD, OP_WRD = 4'hE, OP_RSVD = 4'hF
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_CMD, S_ADDR, S_WBUF, S_WSGL,
    S_RBUF, S_RSGL, S_WAIT, S_FIN
  } st_e;
endpackage

// File: rtl/nseq_addr_ser.sv
module nseq_addr_ser #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  input  logic [2:0]   nbytes,
  input  logic         step,
  output logic [7:0]   byte_o,
  output logic         last_o
);
  logic [W-1:0] sh_q;
  logic [2:0]   left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= value;
      left_q <= nbytes;
    end else if (step) begin
      sh_q   <= sh_q >> 8;
      left_q <= left_q - 3'd1;
    end
  end

  assign byte_o = sh_q[7:0];
  assign last_o = (left_q == 3'd1);

  p_step_has_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> left_q != 3'd0);
endmodule

// File: rtl/nseq_wait_timer.sv
module nseq_wait_timer #(
  parameter int TMO_SHIFT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic [3:0] tmo,
  output logic       expired
);
  localparam int CW = TMO_SHIFT + 6;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit   = CW'(5'({1'b0, tmo}) + 5'd1) << TMO_SHIFT;
  assign expired = run && (cnt_q == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + CW'(1);
  end

  p_wait_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q < limit);
endmodule

// File: rtl/nand_op_sequencer.sv
module nand_op_sequencer
  import nseq_pkg::*;
#(
  parameter int TMO_SHIFT = 8,
  parameter int BC_W      = 12,
  parameter int NOPS      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [4*NOPS-1:0] prog_word,
  input  logic [31:0]     cmd_word,
  input  logic [23:0]     blk_addr,
  input  logic [31:0]     page_addr,
  input  logic [31:0]     user_addr,
  input  logic [BC_W-1:0] byte_cnt,
  input  logic [1:0]      addr_cyc,
  input  logic [3:0]      wait_tmo,
  input  logic            sgl_two,
  input  logic [15:0]     sgl_wdata,
  output logic [15:0]     sgl_rdata,
  output logic            busy,
  output logic            done,
  output logic            cmd_cplt,
  output logic            wait_to,
  output logic            nf_cle,
  output logic            nf_ale,
  output logic            nf_we,
  output logic            nf_re,
  output logic [7:0]      nf_dq_o,
  input  logic [7:0]      nf_dq_i,
  input  logic            nf_ready,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [7:0]      s_data,
  output logic            m_valid,
  input  logic            m_ready,
  output logic [7:0]      m_data
);
  localparam int PW = 4 * NOPS;
  localparam int IW = $clog2(NOPS + 1);

  st_e             st_q, post_q;
  logic [PW-1:0]   prog_q;
  logic [IW-1:0]   idx_q;
  logic [BC_W-1:0] cnt_q;
  logic            hi_q;
  logic [1:0]      sel_q;
  logic            mv_q;
  logic [7:0]      md_q;
  logic [15:0]     srd_q;
  logic            cc_q, to_q, done_q;

  op_e  op;
  logic seq_end, addr_load, addr_last, tmo_hit;
  logic wbuf_go, rbuf_go;
  logic [31:0] addr_val;
  logic [2:0]  addr_n;
  logic [7:0]  addr_byte, cmd_byte;

  assign op      = op_e'(prog_q[PW-1 -: 4]);
  assign seq_end = (idx_q == IW'(NOPS)) || (op == OP_END) || (op == OP_RSVD);

  assign addr_load = (st_q == S_FETCH) && !seq_end &&
                     (op == OP_COL || op == OP_ROW || op == OP_USR);
  always_comb begin
    case (op)
      OP_COL:  addr_val = {21'd0, page_addr[10:0]};
      OP_ROW:  addr_val = {2'b00, blk_addr, page_addr[17:12]};
      default: addr_val = user_addr;
    endcase
    addr_n = (op == OP_COL) ? 3'd2 : ({1'b0, addr_cyc} + 3'd1);
  end

  nseq_addr_ser #(.W(32)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .value(addr_val),
    .nbytes(addr_n), .step(st_q == S_ADDR), .byte_o(addr_byte),
    .last_o(addr_last)
  );

  nseq_wait_timer #(.TMO_SHIFT(TMO_SHIFT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(st_q != S_WAIT),
    .run((st_q == S_WAIT) && !nf_ready), .tmo(wait_tmo), .expired(tmo_hit)
  );

  always_comb begin
    case (sel_q)
      2'd0:    cmd_byte = cmd_word[31:24];
      2'd1:    cmd_byte = cmd_word[23:16];
      2'd2:    cmd_byte = cmd_word[15:8];
      default: cmd_byte = cmd_word[7:0];
    endcase
  end

  assign s_ready = (st_q == S_WBUF) && (cnt_q != '0);
  assign wbuf_go = s_ready && s_valid;
  assign rbuf_go = (st_q == S_RBUF) && (cnt_q != '0) && (!mv_q || m_ready);

  assign nf_cle = (st_q == S_CMD);
  assign nf_ale = (st_q == S_ADDR);
  assign nf_we  = nf_cle || nf_ale || wbuf_go || (st_q == S_WSGL);
  assign nf_re  = rbuf_go || (st_q == S_RSGL);

  always_comb begin
    case (st_q)
      S_CMD:   nf_dq_o = cmd_byte;
      S_ADDR:  nf_dq_o = addr_byte;
      S_WBUF:  nf_dq_o = s_data;
      S_WSGL:  nf_dq_o = hi_q ? sgl_wdata[15:8] : sgl_wdata[7:0];
      default: nf_dq_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; post_q <= S_IDLE; prog_q <= '0; idx_q <= '0;
      cnt_q <= '0; hi_q <= 1'b0; sel_q <= '0; srd_q <= '0;
      cc_q <= 1'b0; to_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          prog_q <= prog_word; idx_q <= '0;
          cc_q <= 1'b0; to_q <= 1'b0; st_q <= S_FETCH;
        end
        S_FETCH: if (seq_end) st_q <= S_FIN;
        else begin
          idx_q  <= idx_q + IW'(1);
          prog_q <= {prog_q[PW-5:0], 4'h0};
          hi_q   <= 1'b0;
          case (op)
            OP_COL, OP_ROW, OP_USR: st_q <= S_ADDR;
            OP_CMD0, OP_CMD1, OP_CMD2, OP_CMD3: begin
              sel_q <= op[1:0]; st_q <= S_CMD;
            end
            OP_WBUF: begin cnt_q <= byte_cnt; st_q <= S_WBUF; end
            OP_RBUF: begin cnt_q <= byte_cnt; st_q <= S_RBUF; end
            OP_WSGL: begin cnt_q <= sgl_two ? BC_W'(2) : BC_W'(1); st_q <= S_WSGL; end
            OP_RSGL: begin cnt_q <= sgl_two ? BC_W'(2) : BC_W'(1); st_q <= S_RSGL; end
            OP_WCMD0: begin sel_q <= 2'd0; post_q <= S_CMD; st_q <= S_WAIT; end
            OP_WCMD1: begin sel_q <= 2'd1; post_q <= S_CMD; st_q <= S_WAIT; end
            default: begin cnt_q <= byte_cnt; post_q <= S_RBUF; st_q <= S_WAIT; end
          endcase
        end
        S_CMD:  st_q <= S_FETCH;
        S_ADDR: if (addr_last) st_q <= S_FETCH;
        S_WBUF, S_RBUF: begin
          if (cnt_q == '0) st_q <= S_FETCH;
          else if (wbuf_go || rbuf_go) cnt_q <= cnt_q - BC_W'(1);
        end
        S_WSGL, S_RSGL: begin
          if (st_q == S_RSGL) begin
            if (hi_q) srd_q[15:8] <= nf_dq_i;
            else      srd_q[7:0]  <= nf_dq_i;
          end
          hi_q  <= 1'b1;
          cnt_q <= cnt_q - BC_W'(1);
          if (cnt_q == BC_W'(1)) st_q <= S_FETCH;
        end
        S_WAIT: begin
          if (nf_ready) st_q <= post_q;
          else if (tmo_hit) begin to_q <= 1'b1; st_q <= S_FIN; end
        end
        S_FIN: if (!mv_q) begin
          done_q <= 1'b1; cc_q <= !to_q; st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_q <= 1'b0; md_q <= '0;
    end else if (rbuf_go) begin
      mv_q <= 1'b1; md_q <= nf_dq_i;
    end else if (m_ready) begin
      mv_q <= 1'b0;
    end
  end

  assign m_valid   = mv_q;
  assign m_data    = md_q;
  assign sgl_rdata = srd_q;
  assign busy      = (st_q != S_IDLE);
  assign done      = done_q;
  assign cmd_cplt  = cc_q;
  assign wait_to   = to_q;

  p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale) && !(nf_we && nf_re));
  p_cle_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (nf_cle || nf_ale) |-> nf_we);
  p_mvalid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  p_done_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !m_valid);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_cplt && wait_to));
  p_sready_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> busy);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!nf_we && !nf_re));
endmodule

// File: tb/tb_nand_op_sequencer.sv
module tb_nand_op_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] prog_word = '0, cmd_word = 32'h11223344;
  logic [23:0] blk_addr = '0;
  logic [31:0] page_addr = '0, user_addr = '0;
  logic [11:0] byte_cnt = '0;
  logic [1:0]  addr_cyc = '0;
  logic [3:0]  wait_tmo = 4'hF;
  logic        sgl_two = 1'b0;
  logic [15:0] sgl_wdata = '0, sgl_rdata;
  logic busy, done, cmd_cplt, wait_to, nf_cle, nf_ale, nf_we, nf_re;
  logic [7:0] nf_dq_o, nf_dq_i, s_data, m_data;
  logic nf_ready = 1'b1;
  logic s_valid, s_ready, m_valid, m_ready;
  logic tx_en = 1'b0, tx_gap = 1'b0, rx_en = 1'b0, rx_gap = 1'b0;

  int total = 0, bad = 0;
  int cyc = 0, log_n = 0, rd_n = 0, tx_k = 0, rx_n = 0;
  logic [2:0] log_kind [0:1023];
  logic [7:0] log_dq   [0:1023];
  logic [7:0] rx_buf   [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign nf_dq_i = 8'h30 + rd_n[7:0];
  assign s_data  = 8'h50 + tx_k[7:0];
  assign s_valid = tx_en && !(tx_gap && cyc[0]);
  assign m_ready = rx_en && !(rx_gap && cyc[1]);

  nand_op_sequencer #(.TMO_SHIFT(2), .BC_W(12), .NOPS(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .prog_word(prog_word),
    .cmd_word(cmd_word), .blk_addr(blk_addr), .page_addr(page_addr),
    .user_addr(user_addr), .byte_cnt(byte_cnt), .addr_cyc(addr_cyc),
    .wait_tmo(wait_tmo), .sgl_two(sgl_two), .sgl_wdata(sgl_wdata),
    .sgl_rdata(sgl_rdata), .busy(busy), .done(done), .cmd_cplt(cmd_cplt),
    .wait_to(wait_to), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we(nf_we),
    .nf_re(nf_re), .nf_dq_o(nf_dq_o), .nf_dq_i(nf_dq_i),
    .nf_ready(nf_ready), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  // kinds: 1 command, 2 address, 3 data write, 4 read
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (nf_we || nf_re) begin
      log_kind[log_n] <= nf_cle ? 3'd1 : nf_ale ? 3'd2 : nf_we ? 3'd3 : 3'd4;
      log_dq[log_n]   <= nf_re ? nf_dq_i : nf_dq_o;
      log_n <= log_n + 1;
    end
    if (nf_re) rd_n <= rd_n + 1;
    if (s_valid && s_ready) tx_k <= tx_k + 1;
    if (m_valid && m_ready) begin
      rx_buf[rx_n] <= m_data;
      rx_n <= rx_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_ev(input string req, input int i, input logic [2:0] k, input logic [7:0] d);
    chk(req, {21'd0, log_kind[i], log_dq[i]}, {21'd0, k, d});
  endtask

  task automatic pulse_start(input logic [31:0] p);
    @(negedge clk); prog_word = p; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (done !== 1'b1 && n < 3000) begin @(negedge clk); n++; end
    chk({req, " done seen"}, {31'd0, done}, 32'd1);
  endtask

  task automatic run(input logic [31:0] p, input string req);
    pulse_start(p);
    wait_done(req);
  endtask

  task automatic t_reset;
    chk("R12 busy", {31'd0, busy}, 0);
    chk("R12 done", {31'd0, done}, 0);
    chk("R12 flags", {30'd0, cmd_cplt, wait_to}, 0);
    chk("R12 strobes", {28'd0, nf_we, nf_re, nf_cle, nf_ale}, 0);
    chk("R12 streams", {30'd0, s_ready, m_valid}, 0);
  endtask

  task automatic t_cmd_addr;
    int b = log_n;
    blk_addr = 24'h000123; page_addr = 32'h000155A3; addr_cyc = 2'd2;
    run(32'h41250700, "R2");
    chk("R2 cmd_cplt", {31'd0, cmd_cplt}, 1);
    chk("R2 wait_to", {31'd0, wait_to}, 0);
    chk("R2 stops at end opcode", log_n - b, 7);
    chk_ev("R3 cmd0", b, 3'd1, 8'h11);
    chk_ev("R4 col lo", b+1, 3'd2, 8'hA3);
    chk_ev("R4 col hi", b+2, 3'd2, 8'h05);
    chk_ev("R5 row0", b+3, 3'd2, 8'hD5);
    chk_ev("R5 row1", b+4, 3'd2, 8'h48);
    chk_ev("R5 row2", b+5, 3'd2, 8'h00);
    chk_ev("R1 order cmd1", b+6, 3'd1, 8'h22);
  endtask

  task automatic t_eight;
    int b = log_n;
    logic [7:0] e [0:7] = '{8'h33, 8'h44, 8'h33, 8'h44, 8'h11, 8'h22, 8'h33, 8'h44};
    run(32'h67674567, "R1");
    chk("R1 eight slots", log_n - b, 8);
    for (int i = 0; i < 8; i++) chk_ev("R1 R3 slot", b+i, 3'd1, e[i]);
    chk("R1 cmd_cplt", {31'd0, cmd_cplt}, 1);
  endtask

  task automatic t_user;
    int b = log_n;
    user_addr = 32'hDEADBEEF; addr_cyc = 2'd3;
    run(32'h30000000, "R5");
    chk("R5 four bytes", log_n - b, 4);
    chk_ev("R5 ua0", b, 3'd2, 8'hEF);
    chk_ev("R5 ua1", b+1, 3'd2, 8'hBE);
    chk_ev("R5 ua2", b+2, 3'd2, 8'hAD);
    chk_ev("R5 ua3", b+3, 3'd2, 8'hDE);
    b = log_n; addr_cyc = 2'd0;
    run(32'h30000000, "R5");
    chk("R5 one byte", log_n - b, 1);
    chk_ev("R5 ua single", b, 3'd2, 8'hEF);
  endtask

  task automatic t_wbuf;
    int b = log_n;
    int k0 = tx_k;
    byte_cnt = 12'd5; tx_en = 1'b1; tx_gap = 1'b1;
    run(32'h48000000, "R6");
    tx_en = 1'b0; tx_gap = 1'b0;
    chk("R6 events", log_n - b, 6);
    chk_ev("R6 cmd first", b, 3'd1, 8'h11);
    for (int i = 0; i < 5; i++) chk_ev("R6 data", b+1+i, 3'd3, 8'(8'h50 + k0 + i));
    chk("R6 consumed", tx_k - k0, 5);
    b = log_n; k0 = tx_k; byte_cnt = 12'd0; tx_en = 1'b1;
    run(32'h84000000, "R6");
    chk("R6 zero count consumes none", tx_k - k0, 0);
    chk("R6 zero count events", log_n - b, 1);
    chk_ev("R6 zero count cmd", b, 3'd1, 8'h11);
    chk("R6 s_ready idle", {31'd0, s_ready}, 0);
    tx_en = 1'b0;
  endtask

  task automatic t_rbuf;
    int b = log_n;
    int r0 = rd_n;
    int x0 = rx_n;
    byte_cnt = 12'd4; rx_en = 1'b1; rx_gap = 1'b1;
    run(32'hA0000000, "R7");
    chk("R7 drained at done", rx_n - x0, 4);
    chk("R7 m_valid low", {31'd0, m_valid}, 0);
    for (int i = 0; i < 4; i++) begin
      chk_ev("R7 read strobe", b+i, 3'd4, 8'(8'h30 + r0 + i));
      chk("R7 stream data", {24'd0, rx_buf[x0+i]}, {24'd0, 8'(8'h30 + r0 + i)});
    end
    rx_gap = 1'b0;
  endtask

  task automatic t_single;
    int b = log_n;
    int r0;
    sgl_two = 1'b1; sgl_wdata = 16'hBEEF;
    run(32'h90000000, "R8");
    chk("R8 two writes", log_n - b, 2);
    chk_ev("R8 low first", b, 3'd3, 8'hEF);
    chk_ev("R8 high second", b+1, 3'd3, 8'hBE);
    sgl_two = 1'b0; r0 = rd_n; b = log_n;
    run(32'hB0000000, "R8");
    chk("R8 one read", log_n - b, 1);
    chk("R8 rdata low", {24'd0, sgl_rdata[7:0]}, {24'd0, 8'(8'h30 + r0)});
    sgl_two = 1'b1; r0 = rd_n;
    run(32'hB0000000, "R8");
    chk("R8 rdata two", {16'd0, sgl_rdata}, {16'd0, 8'(8'h30 + r0 + 1), 8'(8'h30 + r0)});
    sgl_two = 1'b0;
  endtask

  task automatic t_wait;
    int b = log_n;
    nf_ready = 1'b0; wait_tmo = 4'hF;
    pulse_start(32'hC0000000);
    repeat (10) @(negedge clk);
    chk("R9 no strobe while waiting", log_n - b, 0);
    chk("R9 busy while waiting", {31'd0, busy}, 1);
    pulse_start(32'h50000000);   // R11: ignored while busy
    nf_ready = 1'b1;
    wait_done("R9");
    chk("R11 second start ignored", log_n - b, 1);
    chk_ev("R9 cmd0 after ready", b, 3'd1, 8'h11);
    chk("R9 no timeout", {30'd0, cmd_cplt, wait_to}, 2);
  endtask

  task automatic t_timeout;
    int b = log_n;
    nf_ready = 1'b0; wait_tmo = 4'd1;
    run(32'hD4000000, "R10");
    chk("R10 wait_to set", {31'd0, wait_to}, 1);
    chk("R10 cmd_cplt clear", {31'd0, cmd_cplt}, 0);
    chk("R10 no strobes", log_n - b, 0);
    nf_ready = 1'b1; wait_tmo = 4'hF;
    run(32'h40000000, "R11");
    chk("R11 flags cleared on start", {30'd0, cmd_cplt, wait_to}, 2);
  endtask

  task automatic t_wait_read;
    int b = log_n;
    int r0 = rd_n;
    int x0 = rx_n;
    nf_ready = 1'b0; byte_cnt = 12'd2; rx_en = 1'b1;
    pulse_start(32'hE0000000);
    repeat (3) @(negedge clk);
    chk("R9 idle before ready", log_n - b, 0);
    nf_ready = 1'b1;
    wait_done("R9");
    chk("R9 read count", rx_n - x0, 2);
    chk("R9 read data", {24'd0, rx_buf[x0+1]}, {24'd0, 8'(8'h30 + r0 + 1)});
  endtask

  task automatic t_rsvd;
    int b = log_n;
    run(32'h4F400000, "R2");
    chk("R2 reserved opcode ends", log_n - b, 1);
    chk_ev("R2 only first cmd", b, 3'd1, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd_addr();
    t_eight();
    t_user();
    t_wbuf();
    t_rbuf();
    t_single();
    t_wait();
    t_timeout();
    t_wait_read();
    t_rsvd();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end
endmodule